// File: doc/BRIEF.md
# Message-Based Lock Manager

This block is a central lock server for a multi-core fabric. Cores send it single-cycle request messages naming a core, a lock and an operation (take or give back). No memory location stands behind a lock: ownership is pure bookkeeping kept inside the manager. A core that asks for a free lock is answered on the grant channel one cycle later. A core that asks for a lock someone else holds gets no answer. It is parked in that lock's hardware wait list and simply stalls until the lock is handed to it. Nothing on the request channel ever polls.

When the holder gives a lock back, the oldest parked core becomes owner in that same clock edge, and its grant appears on the next cycle. Malformed requests raise a one-cycle error strobe and change nothing. These are: a give-back from a non-owner, a second wait by a core that already waits, and a re-take of a lock already owned. The manager also watches the wait-for graph continuously. Each waiting core points at the owner of the lock it waits on. When such a chain leads back to its start, the manager raises a deadlock flag and marks the cores that sit on a cycle.

Top module: `lock_mgr`

## Requirements
- R1: After reset no lock is held, no core waits, and gnt_valid, err_valid, deadlock and dl_mask are all zero.
- R2: A request with req_op=0 (take) for a lock that is not held, from a core that is not waiting, makes that core the owner. gnt_valid=1 follows on the next cycle with gnt_core and gnt_lock equal to the request's core and lock.
- R3: A take request for a lock held by another core, from a core that is not waiting, produces neither a grant nor an error. The core is queued on that lock.
- R4: A request with req_op=1 (give back) from the owner of a lock that has waiters passes ownership to the earliest-queued waiter at that edge. That waiter's grant appears on the next cycle. Waiters are served strictly in arrival order.
- R5: A give-back from the owner of a lock with no waiters frees the lock. A later take of that lock is granted per R2.
- R6: A give-back of a free lock, or from a core that is not its owner, is dropped. err_valid=1 on the next cycle, with no grant and no change of ownership.
- R7: A take request from a core that is already waiting, or for a lock the core already owns, is dropped with err_valid=1 on the next cycle.
- R8: One cycle after any state in which some waiting core's chain of links (owner of the awaited lock, repeatedly) returns to that core within NC steps, deadlock=1. dl_mask bit c is then set exactly for each such core c. Both outputs drop one cycle after the cycle is broken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present this cycle |
| req_op | input | 1 | 0 = take lock, 1 = give back lock |
| req_core | input | $clog2(NC) | Requesting core |
| req_lock | input | $clog2(NL) | Target lock |
| gnt_valid | output | 1 | Grant message present |
| gnt_core | output | $clog2(NC) | Core receiving the lock |
| gnt_lock | output | $clog2(NL) | Lock granted |
| err_valid | output | 1 | Previous request was dropped as malformed |
| deadlock | output | 1 | A wait-for cycle exists |
| dl_mask | output | NC | Cores lying on a wait-for cycle |

## Verification
Directed sequences cover the distinct cases one at a time. An uncontended take isolates the one-cycle grant path. Two queued waiters on one lock distinguish arrival-order hand-off from any other order. Non-owner and double-wait requests separate the error path from silent queuing. A two-core crossed take builds a deadlock, and a give-back then breaks it. Random traffic is then concentrated on four locks so that queues fill, hand-offs chain and longer wait cycles form by chance. Every cycle, the grant, error and deadlock outputs are compared with a bench model of owners, waiting lists and chain walks.

// File: rtl/lock_mgr_pkg.sv
package lock_mgr_pkg;
    typedef enum logic {
        OP_TAKE = 1'b0,
        OP_GIVE = 1'b1
    } lk_op_e;
endpackage

// File: rtl/lock_waitq.sv
// Arrival-ordered list of waiting core ids for one lock.
module lock_waitq #(
    parameter int DEPTH = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t         p_d, p_q;
    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] v);
        return (v == PW'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        p_d   = p_q;
        mem_d = mem_q;
        if (push && (p_q.cnt != CW'(DEPTH))) begin
            mem_d[p_q.wp] = din;
            p_d.wp        = wrap_inc(p_q.wp);
        end
        if (pop && (p_q.cnt != '0)) begin
            p_d.rp = wrap_inc(p_q.rp);
        end
        if (push && !pop && (p_q.cnt != CW'(DEPTH))) begin
            p_d.cnt = p_q.cnt + 1'b1;
        end else if (pop && !push && (p_q.cnt != '0)) begin
            p_d.cnt = p_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q   <= '0;
            mem_q <= '{default: '0};
        end else begin
            p_q   <= p_d;
            mem_q <= mem_d;
        end
    end

    assign head  = mem_q[p_q.rp];
    assign empty = (p_q.cnt == '0);
endmodule

// File: rtl/lock_cycle_det.sv
// Walks the wait-for chain from every core; flags cores whose chain closes.
module lock_cycle_det #(
    parameter int NC    = 8,
    parameter int NL    = 16,
    parameter int STEPS = 8
) (
    input  logic [NC-1:0]                      waiting,
    input  logic [NC-1:0][$clog2(NL)-1:0]      wlock,
    input  logic [NL-1:0][$clog2(NC)-1:0]      owner,
    output logic [NC-1:0]                      found
);
    localparam int CIW = $clog2(NC);

    for (genvar g = 0; g < NC; g++) begin : g_walk
        always_comb begin
            logic [CIW-1:0] cur;
            logic           alive;
            cur      = CIW'(g);
            alive    = 1'b1;
            found[g] = 1'b0;
            for (int s = 0; s < STEPS; s++) begin
                if (alive) begin
                    if (waiting[cur]) begin
                        cur = owner[wlock[cur]];
                        if (cur == CIW'(g)) begin
                            found[g] = 1'b1;
                            alive    = 1'b0;
                        end
                    end else begin
                        alive = 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lock_mgr.sv
module lock_mgr
    import lock_mgr_pkg::*;
#(
    parameter int NC = 8,
    parameter int NL = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_op,
    input  logic [$clog2(NC)-1:0] req_core,
    input  logic [$clog2(NL)-1:0] req_lock,
    output logic                  gnt_valid,
    output logic [$clog2(NC)-1:0] gnt_core,
    output logic [$clog2(NL)-1:0] gnt_lock,
    output logic                  err_valid,
    output logic                  deadlock,
    output logic [NC-1:0]         dl_mask
);
    localparam int CIW = $clog2(NC);
    localparam int LIW = $clog2(NL);

    typedef struct packed {
        logic [NL-1:0]           held;
        logic [NL-1:0][CIW-1:0]  owner;
        logic [NC-1:0]           waiting;
        logic [NC-1:0][LIW-1:0]  wlock;
        logic                    gnt_v;
        logic [CIW-1:0]          gnt_c;
        logic [LIW-1:0]          gnt_l;
        logic                    err_v;
        logic                    dl;
        logic [NC-1:0]           dl_mask;
    } st_t;

    st_t                    s_d, s_q;
    logic [NL-1:0]          q_push, q_pop, q_empty;
    logic [NL-1:0][CIW-1:0] q_head;
    logic [NC-1:0]          cyc_found;

    for (genvar i = 0; i < NL; i++) begin : g_q
        lock_waitq #(.DEPTH(NC), .W(CIW)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[i]),
            .pop   (q_pop[i]),
            .din   (req_core),
            .head  (q_head[i]),
            .empty (q_empty[i])
        );
    end

    lock_cycle_det #(.NC(NC), .NL(NL), .STEPS(NC)) u_det (
        .waiting (s_q.waiting),
        .wlock   (s_q.wlock),
        .owner   (s_q.owner),
        .found   (cyc_found)
    );

    always_comb begin
        logic [CIW-1:0] nxt;
        s_d        = s_q;
        s_d.gnt_v  = 1'b0;
        s_d.err_v  = 1'b0;
        s_d.dl     = |cyc_found;
        s_d.dl_mask = cyc_found;
        q_push     = '0;
        q_pop      = '0;
        nxt        = q_head[req_lock];
        if (req_valid) begin
            if (req_op == OP_TAKE) begin
                if (s_q.waiting[req_core] ||
                    (s_q.held[req_lock] && (s_q.owner[req_lock] == req_core))) begin
                    s_d.err_v = 1'b1;
                end else if (!s_q.held[req_lock]) begin
                    s_d.held[req_lock]  = 1'b1;
                    s_d.owner[req_lock] = req_core;
                    s_d.gnt_v           = 1'b1;
                    s_d.gnt_c           = req_core;
                    s_d.gnt_l           = req_lock;
                end else begin
                    q_push[req_lock]       = 1'b1;
                    s_d.waiting[req_core]  = 1'b1;
                    s_d.wlock[req_core]    = req_lock;
                end
            end else begin
                if (!s_q.held[req_lock] || (s_q.owner[req_lock] != req_core)) begin
                    s_d.err_v = 1'b1;
                end else if (q_empty[req_lock]) begin
                    s_d.held[req_lock] = 1'b0;
                end else begin
                    q_pop[req_lock]     = 1'b1;
                    s_d.owner[req_lock] = nxt;
                    s_d.waiting[nxt]    = 1'b0;
                    s_d.gnt_v           = 1'b1;
                    s_d.gnt_c           = nxt;
                    s_d.gnt_l           = req_lock;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_valid = s_q.gnt_v;
    assign gnt_core  = s_q.gnt_c;
    assign gnt_lock  = s_q.gnt_l;
    assign err_valid = s_q.err_v;
    assign deadlock  = s_q.dl;
    assign dl_mask   = s_q.dl_mask;
endmodule

// File: rtl/lock_mgr_chk.sv
module lock_mgr_chk #(
    parameter int NC = 8,
    parameter int NL = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_op,
    input logic [$clog2(NC)-1:0]          req_core,
    input logic [$clog2(NL)-1:0]          req_lock,
    input logic                           gnt_valid,
    input logic [$clog2(NC)-1:0]          gnt_core,
    input logic [$clog2(NL)-1:0]          gnt_lock,
    input logic                           err_valid,
    input logic                           deadlock,
    input logic [NC-1:0]                  dl_mask,
    input logic [NL-1:0]                  held,
    input logic [NL-1:0][$clog2(NC)-1:0]  owner,
    input logic [NC-1:0]                  waiting
);
    a_r2_free_take_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op && !held[req_lock] && !waiting[req_core])
        |=> (gnt_valid && gnt_core == $past(req_core) && gnt_lock == $past(req_lock)));

    a_r3_busy_take_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op && held[req_lock] && owner[req_lock] != req_core
         && !waiting[req_core])
        |=> (!gnt_valid && !err_valid && waiting[$past(req_core)]));

    a_r4_grant_matches_owner: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (held[gnt_lock] && owner[gnt_lock] == gnt_core && !waiting[gnt_core]));

    a_r4_no_unprompted_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!gnt_valid && !err_valid));

    a_r6_bad_give_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op && (!held[req_lock] || owner[req_lock] != req_core))
        |=> (err_valid && !gnt_valid && $stable(held) && $stable(owner)));

    a_r8_mask_on_waiters: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |-> (dl_mask != '0 && (dl_mask & ~$past(waiting)) == '0));
endmodule

bind lock_mgr lock_mgr_chk #(.NC(NC), .NL(NL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_core  (req_core),
    .req_lock  (req_lock),
    .gnt_valid (gnt_valid),
    .gnt_core  (gnt_core),
    .gnt_lock  (gnt_lock),
    .err_valid (err_valid),
    .deadlock  (deadlock),
    .dl_mask   (dl_mask),
    .held      (s_q.held),
    .owner     (s_q.owner),
    .waiting   (s_q.waiting)
);

// File: tb/lock_mgr_bench.sv
`timescale 1ns/1ps
module lock_mgr_bench;
    localparam int NC = 8;
    localparam int NL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_op = 1'b0;
    logic [2:0] req_core = '0;
    logic [3:0] req_lock = '0;
    logic       gnt_valid, err_valid, deadlock;
    logic [2:0] gnt_core;
    logic [3:0] gnt_lock;
    logic [7:0] dl_mask;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lock_mgr #(.NC(NC), .NL(NL)) u_lock_mgr (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_core(req_core), .req_lock(req_lock), .gnt_valid(gnt_valid),
        .gnt_core(gnt_core), .gnt_lock(gnt_lock), .err_valid(err_valid),
        .deadlock(deadlock), .dl_mask(dl_mask)
    );

    // reference model
    bit m_held [NL];
    int m_owner [NL];
    bit m_wait [NC];
    int m_wlock [NC];
    int m_q [NL][$];

    function automatic void model_clear();
        for (int i = 0; i < NL; i++) begin
            m_held[i] = 0; m_owner[i] = 0; m_q[i].delete();
        end
        for (int i = 0; i < NC; i++) begin
            m_wait[i] = 0; m_wlock[i] = 0;
        end
    endfunction

    function automatic logic [7:0] model_mask();
        logic [7:0] m = '0;
        for (int c = 0; c < NC; c++) begin
            int cur = c;
            for (int s = 0; s < NC; s++) begin
                if (!m_wait[cur]) break;
                cur = m_owner[m_wlock[cur]];
                if (cur == c) begin m[c] = 1'b1; break; end
            end
        end
        return m;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        req_valid = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        model_clear();
        @(posedge clk); #1;
        check("R1", "gnt_valid", gnt_valid, 0);
        check("R1", "err_valid", err_valid, 0);
        check("R1", "deadlock", deadlock, 0);
        check("R1", "dl_mask", dl_mask, 0);
    endtask

    // One request (or idle when v==0); checks replies one edge later.
    task automatic step(bit v, bit op, int c, int l);
        logic [7:0] exp_mask;
        bit eg = 0, ee = 0;
        int ec = 0, el = 0;
        string tag = "R3";
        exp_mask = model_mask();
        if (v) begin
            if (!op) begin
                if (m_wait[c] || (m_held[l] && m_owner[l] == c)) begin
                    ee = 1; tag = "R7";
                end else if (!m_held[l]) begin
                    m_held[l] = 1; m_owner[l] = c;
                    eg = 1; ec = c; el = l; tag = "R2";
                end else begin
                    m_q[l].push_back(c); m_wait[c] = 1; m_wlock[c] = l; tag = "R3";
                end
            end else begin
                if (!m_held[l] || m_owner[l] != c) begin
                    ee = 1; tag = "R6";
                end else if (m_q[l].size() == 0) begin
                    m_held[l] = 0; tag = "R5";
                end else begin
                    int h = m_q[l].pop_front();
                    m_owner[l] = h; m_wait[h] = 0;
                    eg = 1; ec = h; el = l; tag = "R4";
                end
            end
        end
        @(negedge clk);
        req_valid = v; req_op = op; req_core = 3'(c); req_lock = 4'(l);
        @(posedge clk); #1;
        req_valid = 0;
        check(tag, "gnt_valid", gnt_valid, eg);
        check(tag, "err_valid", err_valid, ee);
        if (eg) begin
            check(tag, "gnt_core", gnt_core, ec);
            check(tag, "gnt_lock", gnt_lock, el);
        end
        check("R8", "dl_mask", dl_mask, exp_mask);
        check("R8", "deadlock", deadlock, exp_mask != 0);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        do_reset();
        // R2 uncontended take
        step(1, 0, 1, 3);
        // R3 two waiters in order
        step(1, 0, 2, 3);
        step(1, 0, 4, 3);
        // R7 double wait and re-take of own lock
        step(1, 0, 2, 5);
        step(1, 0, 1, 3);
        // R6 give-back by non-owner and of a free lock
        step(1, 1, 2, 3);
        step(1, 1, 0, 9);
        // R4 hand-off in arrival order
        step(1, 1, 1, 3);
        step(1, 1, 2, 3);
        // R5 free then retake
        step(1, 1, 4, 3);
        step(1, 0, 5, 3);
        // R8 crossed takes
        step(1, 0, 0, 0);
        step(1, 0, 6, 1);
        step(1, 0, 0, 1);
        step(1, 0, 6, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        step(1, 1, 6, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        // random phase
        for (int blk = 0; blk < 10; blk++) begin
            do_reset();
            for (int n = 0; n < 200; n++) begin
                int c = int'($urandom_range(NC - 1));
                int l = int'($urandom_range(3));
                bit op = 1'($urandom_range(1));
                if (op && $urandom_range(3) != 0) begin
                    for (int k = 0; k < NL; k++)
                        if (m_held[k] && m_owner[k] == c) l = k;
                end
                step($urandom_range(7) != 0, op, c, l);
            end
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule